// File: doc/BRIEF.md
# Byte-Granular Mailbox Bank with Interrupt Generation

This block holds two banks of 32-bit mailboxes between a host side and a local side. Each mailbox is split into four bytes. The "up" bank carries data from the local side to the host: the local side writes it and the host reads it. The "down" bank carries data the other way: the host writes it and the local side reads it. Every byte has its own full flag. A write from the producing side sets the flag of each enabled byte, and a read from the consuming side clears it. Read data is combinational from the addressed mailbox.

There are two active-low interrupt outputs, one for each side. Each has a 6-bit selection input that names one byte and one kind of event:

- **Fill event:** the side's incoming byte goes from empty to full.
- **Drain event:** the side's outgoing byte goes from full to empty.

An interrupt stays pending until a clear pulse, or until its enable bit is cleared. A strap input selects pin mode. In pin mode, up-bank mailbox 3, byte 3 is loaded from dedicated pins instead of by local writes. This lets external hardware raise a host interrupt with no local bus cycle.

Top module: `mbx_irq_top`

## Requirements
- R1: After reset, all full flags are 0, all mailbox bytes are 0, and both `l_irq_n` and `h_irq_n` are 1.
- R2: A producer write (`l_wr` to the up bank, `h_wr` to the down bank) stores the bytes of `*_wdata` that are enabled by `*_be` (bit k = byte k, bits 8k+7..8k) into mailbox `*_mb`. It sets their full flags at the next clock edge, where flag index = mailbox*4 + byte. Other bytes keep their data and flags.
- R3: A consumer read (`h_rd` on the up bank, `l_rd` on the down bank) returns the whole addressed mailbox on `*_rdata` in the same cycle. It clears the full flags of the enabled bytes at the next edge.
- R4: When a byte is written and read in the same cycle, the read returns the old data and the flag ends full. This counts as a fill event if the byte was empty, and never as a drain event.
- R5: The selection input `*_irq_cfg` is laid out as: bits 1:0 = byte, bits 3:2 = mailbox, bit 4 = event kind, bit 5 = enable. For the local interrupt, kind 1 watches the down-bank byte for a fill event, and kind 0 watches the up-bank byte for a drain event. If the enable bit is set, the watched event drives `l_irq_n` low at the edge where the flag changes.
- R6: The host interrupt works the same way. Kind 1 watches the up-bank byte for a fill event, and kind 0 watches the down-bank byte for a drain event. The result drives `h_irq_n`.
- R7: Only the selected byte can raise an interrupt. Accesses to other bytes have no effect on it, and neither does rewriting a byte that is already full.
- R8: While the enable bit is 0, the interrupt output is 1 from the next edge on. Events that occur while it is disabled are discarded.
- R9: A clear pulse (`l_irq_clr` / `h_irq_clr`) releases a pending interrupt at the next edge. If an event arrives in the same cycle as the clear, the interrupt stays asserted.
- R10: With `pin_mode`=1, `pin_stb` writes `pin_data` into up mailbox 3, byte 3 and sets flag 15, and local writes to that byte are ignored. With `pin_mode`=0, `pin_stb` has no effect.
- R11: A pin write into an empty up mailbox 3, byte 3 is a fill event, so a host interrupt with selection 0x3F asserts `h_irq_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_wr | input | 1 | Host write into the down bank |
| h_rd | input | 1 | Host read of the up bank |
| h_mb | input | 2 | Host mailbox index |
| h_be | input | 4 | Host byte enables |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Up-bank mailbox `h_mb` |
| l_wr | input | 1 | Local write into the up bank |
| l_rd | input | 1 | Local read of the down bank |
| l_mb | input | 2 | Local mailbox index |
| l_be | input | 4 | Local byte enables |
| l_wdata | input | 32 | Local write data |
| l_rdata | output | 32 | Down-bank mailbox `l_mb` |
| l_irq_cfg | input | 6 | Local interrupt selection |
| l_irq_clr | input | 1 | Local interrupt clear pulse |
| l_irq_n | output | 1 | Local interrupt, active low |
| h_irq_cfg | input | 6 | Host interrupt selection |
| h_irq_clr | input | 1 | Host interrupt clear pulse |
| h_irq_n | output | 1 | Host interrupt, active low |
| pin_mode | input | 1 | Strap: pin access to up mailbox 3, byte 3 |
| pin_stb | input | 1 | Pin write strobe |
| pin_data | input | 8 | Pin write data |
| up_full | output | 16 | Up-bank full flags |
| dn_full | output | 16 | Down-bank full flags |

## Verification
Two collisions can happen in one cycle, and both are provoked on purpose.

The first is a producer write and a consumer read of the same byte. The bench issues a host write and a local read to down mailbox 2, byte 0 together. It checks that the read returns the old value, that the flag stays set, and that the new value appears afterwards.

The second is an interrupt event and a clear pulse. The bench pulses `l_irq_clr` in the same cycle as the host read that drains the watched byte. It expects `l_irq_n` to stay low, then to go high after a clear pulse with no event.

A behavioural model that tracks the bytes, flags and pending bits is compared with every output on every clock.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int BYTES_PER_MB = 4;
    localparam int BYTE_W       = 8;

    typedef enum logic {
        SRC_DRAIN = 1'b0,
        SRC_FILL  = 1'b1
    } irq_src_e;
endpackage

// File: rtl/mbx_bank.sv
module mbx_bank
    import mbx_pkg::*;
#(
    parameter int NMB     = 4,
    parameter int EXT_IDX = 15,
    localparam int MBW    = $clog2(NMB),
    localparam int NB     = NMB * BYTES_PER_MB,
    localparam int DW     = BYTES_PER_MB * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MBW-1:0]    wr_mb,
    input  logic [3:0]        wr_be,
    input  logic [DW-1:0]     wr_data,
    input  logic              rd_en,
    input  logic [MBW-1:0]    rd_mb,
    input  logic [3:0]        rd_be,
    input  logic              ext_mode,
    input  logic              ext_stb,
    input  logic [BYTE_W-1:0] ext_data,
    output logic [DW-1:0]     rd_data,
    output logic [NB-1:0]     full,
    output logic [NB-1:0]     fill_evt,
    output logic [NB-1:0]     drain_evt
);
    typedef struct packed {
        logic [NB-1:0][BYTE_W-1:0] mem;
        logic [NB-1:0]             full;
    } bank_t;

    bank_t st_d, st_q;

    logic [NB-1:0]             wr_hit;
    logic [NB-1:0]             rd_hit;
    logic [NB-1:0][BYTE_W-1:0] wr_byte;

    for (genvar i = 0; i < NB; i++) begin : g_byte
        localparam int MBI = i / BYTES_PER_MB;
        localparam int BI  = i % BYTES_PER_MB;
        logic bus_hit;
        assign bus_hit   = wr_en && (wr_mb == MBW'(MBI)) && wr_be[BI];
        assign rd_hit[i] = rd_en && (rd_mb == MBW'(MBI)) && rd_be[BI];
        if (i == EXT_IDX) begin : g_ext
            assign wr_hit[i]  = ext_mode ? ext_stb : bus_hit;
            assign wr_byte[i] = ext_mode ? ext_data : wr_data[BI*BYTE_W +: BYTE_W];
        end else begin : g_bus
            assign wr_hit[i]  = bus_hit;
            assign wr_byte[i] = wr_data[BI*BYTE_W +: BYTE_W];
        end
    end

    always_comb begin
        st_d      = st_q;
        fill_evt  = '0;
        drain_evt = '0;
        for (int i = 0; i < NB; i++) begin
            if (wr_hit[i]) begin
                st_d.mem[i]  = wr_byte[i];
                st_d.full[i] = 1'b1;
                fill_evt[i]  = ~st_q.full[i];
            end else if (rd_hit[i]) begin
                st_d.full[i] = 1'b0;
                drain_evt[i] = st_q.full[i];
            end
        end
    end

    always_comb begin
        for (int k = 0; k < BYTES_PER_MB; k++) begin
            rd_data[k*BYTE_W +: BYTE_W] = st_q.mem[{rd_mb, 2'(k)}];
        end
    end

    assign full = st_q.full;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/mbx_irq_ch.sv
module mbx_irq_ch
    import mbx_pkg::*;
#(
    parameter int NB     = 16,
    localparam int IDXW  = $clog2(NB),
    localparam int CFGW  = IDXW + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CFGW-1:0] cfg,
    input  logic            clr,
    input  logic [NB-1:0]   fill_evt,
    input  logic [NB-1:0]   drain_evt,
    output logic            irq_n
);
    typedef struct packed {
        logic pend;
    } ch_t;

    ch_t st_d, st_q;

    logic [IDXW-1:0] sel_idx;
    irq_src_e        sel_src;
    logic            sel_en;
    logic            sel_evt;

    assign sel_idx = cfg[IDXW-1:0];
    assign sel_src = irq_src_e'(cfg[IDXW]);
    assign sel_en  = cfg[IDXW+1];

    always_comb begin
        st_d    = st_q;
        sel_evt = (sel_src == SRC_FILL) ? fill_evt[sel_idx] : drain_evt[sel_idx];
        st_d.pend = sel_en & ((st_q.pend & ~clr) | sel_evt);
    end

    assign irq_n = ~st_q.pend;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/mbx_irq_top.sv
module mbx_irq_top
    import mbx_pkg::*;
#(
    parameter int NMB      = 4,
    parameter int PIN_MB   = 3,
    parameter int PIN_BYTE = 3,
    localparam int MBW     = $clog2(NMB),
    localparam int NB      = NMB * BYTES_PER_MB,
    localparam int CFGW    = $clog2(NB) + 2,
    localparam int DW      = BYTES_PER_MB * BYTE_W,
    localparam int PIN_IDX = PIN_MB * BYTES_PER_MB + PIN_BYTE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_wr,
    input  logic              h_rd,
    input  logic [MBW-1:0]    h_mb,
    input  logic [3:0]        h_be,
    input  logic [DW-1:0]     h_wdata,
    output logic [DW-1:0]     h_rdata,
    input  logic              l_wr,
    input  logic              l_rd,
    input  logic [MBW-1:0]    l_mb,
    input  logic [3:0]        l_be,
    input  logic [DW-1:0]     l_wdata,
    output logic [DW-1:0]     l_rdata,
    input  logic [CFGW-1:0]   l_irq_cfg,
    input  logic              l_irq_clr,
    output logic              l_irq_n,
    input  logic [CFGW-1:0]   h_irq_cfg,
    input  logic              h_irq_clr,
    output logic              h_irq_n,
    input  logic              pin_mode,
    input  logic              pin_stb,
    input  logic [BYTE_W-1:0] pin_data,
    output logic [NB-1:0]     up_full,
    output logic [NB-1:0]     dn_full
);
    logic [NB-1:0] up_fill, up_drain, dn_fill, dn_drain;

    // local -> host bank; one byte optionally fed from pins
    mbx_bank #(.NMB(NMB), .EXT_IDX(PIN_IDX)) u_up (
        .clk(clk), .rst_n(rst_n),
        .wr_en(l_wr), .wr_mb(l_mb), .wr_be(l_be), .wr_data(l_wdata),
        .rd_en(h_rd), .rd_mb(h_mb), .rd_be(h_be),
        .ext_mode(pin_mode), .ext_stb(pin_stb), .ext_data(pin_data),
        .rd_data(h_rdata), .full(up_full),
        .fill_evt(up_fill), .drain_evt(up_drain)
    );

    // host -> local bank; no pin path (index beyond range)
    mbx_bank #(.NMB(NMB), .EXT_IDX(NB)) u_dn (
        .clk(clk), .rst_n(rst_n),
        .wr_en(h_wr), .wr_mb(h_mb), .wr_be(h_be), .wr_data(h_wdata),
        .rd_en(l_rd), .rd_mb(l_mb), .rd_be(l_be),
        .ext_mode(1'b0), .ext_stb(1'b0), .ext_data('0),
        .rd_data(l_rdata), .full(dn_full),
        .fill_evt(dn_fill), .drain_evt(dn_drain)
    );

    // local interrupt: incoming = down bank, outgoing = up bank
    mbx_irq_ch #(.NB(NB)) u_lirq (
        .clk(clk), .rst_n(rst_n), .cfg(l_irq_cfg), .clr(l_irq_clr),
        .fill_evt(dn_fill), .drain_evt(up_drain), .irq_n(l_irq_n)
    );

    // host interrupt: incoming = up bank, outgoing = down bank
    mbx_irq_ch #(.NB(NB)) u_hirq (
        .clk(clk), .rst_n(rst_n), .cfg(h_irq_cfg), .clr(h_irq_clr),
        .fill_evt(up_fill), .drain_evt(dn_drain), .irq_n(h_irq_n)
    );
endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk #(
    parameter int NMB      = 4,
    parameter int PIN_IDX  = 15,
    localparam int MBW     = $clog2(NMB),
    localparam int NB      = NMB * 4,
    localparam int CFGW    = $clog2(NB) + 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            h_wr,
    input logic            h_rd,
    input logic [MBW-1:0]  h_mb,
    input logic [3:0]      h_be,
    input logic            l_wr,
    input logic            l_rd,
    input logic [MBW-1:0]  l_mb,
    input logic [3:0]      l_be,
    input logic [CFGW-1:0] l_irq_cfg,
    input logic [CFGW-1:0] h_irq_cfg,
    input logic            l_irq_n,
    input logic            h_irq_n,
    input logic            pin_mode,
    input logic            pin_stb,
    input logic [NB-1:0]   up_full,
    input logic [NB-1:0]   dn_full
);
    logic [NB-1:0] l_mask, h_mask, pin_bit;

    assign l_mask  = {{(NB-4){1'b0}}, l_be} << (l_mb * 4);
    assign h_mask  = {{(NB-4){1'b0}}, h_be} << (h_mb * 4);
    assign pin_bit = {{(NB-1){1'b0}}, 1'b1} << PIN_IDX;

    a_r2_up_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
        l_wr && !pin_mode |=> ((up_full & $past(l_mask)) == $past(l_mask)));

    a_r2_dn_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
        h_wr |=> ((dn_full & $past(h_mask)) == $past(h_mask)));

    a_r3_up_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        h_rd && !l_wr && !(pin_mode && pin_stb) |=> ((up_full & $past(h_mask)) == '0));

    a_r3_dn_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        l_rd && !h_wr |=> ((dn_full & $past(l_mask)) == '0));

    a_r10_pin_byte_protected: assert property (@(posedge clk) disable iff (!rst_n)
        pin_mode && !pin_stb && !h_rd |=> ((up_full & pin_bit) == $past(up_full & pin_bit)));

    a_r1_up_flag_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        (|(up_full & ~$past(up_full))) |-> $past(l_wr || (pin_mode && pin_stb)));

    a_r8_local_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !l_irq_cfg[CFGW-1] |=> l_irq_n);

    a_r8_host_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !h_irq_cfg[CFGW-1] |=> h_irq_n);

    a_r5_local_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(l_irq_n) |-> $past(l_irq_cfg[CFGW-1]));

    a_r6_host_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(h_irq_n) |-> $past(h_irq_cfg[CFGW-1]));
endmodule

bind mbx_irq_top mbx_irq_chk #(.NMB(NMB), .PIN_IDX(PIN_IDX)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .h_wr(h_wr), .h_rd(h_rd), .h_mb(h_mb), .h_be(h_be),
    .l_wr(l_wr), .l_rd(l_rd), .l_mb(l_mb), .l_be(l_be),
    .l_irq_cfg(l_irq_cfg), .h_irq_cfg(h_irq_cfg),
    .l_irq_n(l_irq_n), .h_irq_n(h_irq_n),
    .pin_mode(pin_mode), .pin_stb(pin_stb),
    .up_full(up_full), .dn_full(dn_full)
);

// File: tb/mbx_irq_top_tb.sv
module mbx_irq_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_wr = 0, h_rd = 0, l_wr = 0, l_rd = 0;
    logic [1:0]  h_mb = 0, l_mb = 0;
    logic [3:0]  h_be = 0, l_be = 0;
    logic [31:0] h_wdata = 0, l_wdata = 0;
    logic [31:0] h_rdata, l_rdata;
    logic [5:0]  l_irq_cfg = 0, h_irq_cfg = 0;
    logic        l_irq_clr = 0, h_irq_clr = 0;
    logic        l_irq_n, h_irq_n;
    logic        pin_mode = 0, pin_stb = 0;
    logic [7:0]  pin_data = 0;
    logic [15:0] up_full, dn_full;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // behavioural reference state
    logic [7:0] m_up [16];
    logic [7:0] m_dn [16];
    bit         m_upf [16];
    bit         m_dnf [16];
    bit         m_lirq, m_hirq;

    always #5 clk = ~clk;

    mbx_irq_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .h_wr(h_wr), .h_rd(h_rd), .h_mb(h_mb), .h_be(h_be),
        .h_wdata(h_wdata), .h_rdata(h_rdata),
        .l_wr(l_wr), .l_rd(l_rd), .l_mb(l_mb), .l_be(l_be),
        .l_wdata(l_wdata), .l_rdata(l_rdata),
        .l_irq_cfg(l_irq_cfg), .l_irq_clr(l_irq_clr), .l_irq_n(l_irq_n),
        .h_irq_cfg(h_irq_cfg), .h_irq_clr(h_irq_clr), .h_irq_n(h_irq_n),
        .pin_mode(pin_mode), .pin_stb(pin_stb), .pin_data(pin_data),
        .up_full(up_full), .dn_full(dn_full)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) begin
            m_up[i] = 0; m_dn[i] = 0; m_upf[i] = 0; m_dnf[i] = 0;
        end
        m_lirq = 0; m_hirq = 0;
    endtask

    task automatic model_step();
        bit up_fill [16];
        bit up_drain [16];
        bit dn_fill [16];
        bit dn_drain [16];
        bit ev;
        int sel;
        for (int i = 0; i < 16; i++) begin
            bit lw, pw, w, r, hw, lr;
            lw = l_wr && (l_mb == i / 4) && l_be[i % 4] && !(pin_mode && i == 15);
            pw = pin_mode && pin_stb && (i == 15);
            w  = lw || pw;
            r  = h_rd && (h_mb == i / 4) && h_be[i % 4];
            up_fill[i]  = w && !m_upf[i];
            up_drain[i] = r && m_upf[i] && !w;
            if (pw) m_up[i] = pin_data;
            else if (lw) m_up[i] = l_wdata[8 * (i % 4) +: 8];
            if (w) m_upf[i] = 1; else if (r) m_upf[i] = 0;
            hw = h_wr && (h_mb == i / 4) && h_be[i % 4];
            lr = l_rd && (l_mb == i / 4) && l_be[i % 4];
            dn_fill[i]  = hw && !m_dnf[i];
            dn_drain[i] = lr && m_dnf[i] && !hw;
            if (hw) begin m_dn[i] = h_wdata[8 * (i % 4) +: 8]; m_dnf[i] = 1; end
            else if (lr) m_dnf[i] = 0;
        end
        sel = int'(l_irq_cfg[3:0]);
        ev  = l_irq_cfg[4] ? dn_fill[sel] : up_drain[sel];
        m_lirq = l_irq_cfg[5] && ((m_lirq && !l_irq_clr) || ev);
        sel = int'(h_irq_cfg[3:0]);
        ev  = h_irq_cfg[4] ? up_fill[sel] : dn_drain[sel];
        m_hirq = h_irq_cfg[5] && ((m_hirq && !h_irq_clr) || ev);
    endtask

    task automatic compare_all();
        logic [31:0] eh, el;
        logic [15:0] fu, fd;
        for (int k = 0; k < 4; k++) begin
            eh[8 * k +: 8] = m_up[h_mb * 4 + k];
            el[8 * k +: 8] = m_dn[l_mb * 4 + k];
        end
        for (int i = 0; i < 16; i++) begin
            fu[i] = m_upf[i];
            fd[i] = m_dnf[i];
        end
        chk(h_rdata, eh, "R2/R3 model h_rdata");
        chk(l_rdata, el, "R2/R3 model l_rdata");
        chk({16'h0, up_full}, {16'h0, fu}, "R2/R4 model up_full");
        chk({16'h0, dn_full}, {16'h0, fd}, "R2/R4 model dn_full");
        chk({31'h0, l_irq_n}, {31'h0, !m_lirq}, "R5 model l_irq_n");
        chk({31'h0, h_irq_n}, {31'h0, !m_hirq}, "R6 model h_irq_n");
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        h_wr = 0; h_rd = 0; l_wr = 0; l_rd = 0;
        l_irq_clr = 0; h_irq_clr = 0; pin_stb = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk({16'h0, up_full}, 32'h0, "R1 up_full after reset");
        chk({16'h0, dn_full}, 32'h0, "R1 dn_full after reset");
        chk({30'h0, l_irq_n, h_irq_n}, 32'h3, "R1 irq outputs after reset");
        chk(h_rdata, 32'h0, "R1 mailbox data after reset");

        // R5 fill event on down mb1 byte2
        l_irq_cfg = 6'h36;
        h_wr = 1; h_mb = 1; h_be = 4'b0100; h_wdata = 32'hAABBCCDD;
        tick(); idle();
        chk({16'h0, dn_full}, 32'h0040, "R2 dn flag 6 set");
        chk({31'h0, l_irq_n}, 32'h0, "R5 local fill irq");
        // R9 clear
        l_irq_clr = 1; tick(); idle();
        chk({31'h0, l_irq_n}, 32'h1, "R9 clear releases");
        // R7 rewrite of full byte
        h_wr = 1; h_mb = 1; h_be = 4'b0100; tick(); idle();
        chk({31'h0, l_irq_n}, 32'h1, "R7 rewrite full byte no irq");
        // R7 other byte
        h_wr = 1; h_mb = 1; h_be = 4'b0001; tick(); idle();
        chk({31'h0, l_irq_n}, 32'h1, "R7 unselected byte no irq");
        chk({16'h0, dn_full}, 32'h0050, "R2 dn flags 4 and 6");
        // R3 read returns and clears
        l_rd = 1; l_mb = 1; l_be = 4'hF; #1;
        chk(l_rdata, 32'h00BB00DD, "R3 local read data");
        tick(); idle();
        chk({16'h0, dn_full}, 32'h0, "R3 read clears flags");

        // R4 same-cycle write and read
        h_wr = 1; h_mb = 2; h_be = 4'b0001; h_wdata = 32'h11; tick(); idle();
        h_wr = 1; h_wdata = 32'h22; l_rd = 1; l_mb = 2; l_be = 4'b0001; #1;
        chk(l_rdata, 32'h11, "R4 read sees old data");
        tick(); idle();
        chk({16'h0, dn_full}, 32'h0100, "R4 flag ends full");
        chk(l_rdata, 32'h22, "R4 new data after");

        // R5 drain event on up mb0 byte0
        l_irq_cfg = 6'h20;
        l_wr = 1; l_mb = 0; l_be = 4'b0001; l_wdata = 32'h5A; tick(); idle();
        chk({31'h0, l_irq_n}, 32'h1, "R5 write alone no drain irq");
        h_rd = 1; h_mb = 0; h_be = 4'b0001; #1;
        chk(h_rdata, 32'h5A, "R3 host read data");
        tick(); idle();
        chk({31'h0, l_irq_n}, 32'h0, "R5 local drain irq");
        // R8 disable clears and blocks
        l_irq_cfg = 6'h00; tick();
        chk({31'h0, l_irq_n}, 32'h1, "R8 disable releases");
        l_wr = 1; tick(); idle();
        h_rd = 1; tick(); idle();
        chk({31'h0, l_irq_n}, 32'h1, "R8 disabled event dropped");
        // R9 event and clear same cycle
        l_irq_cfg = 6'h20;
        l_wr = 1; tick(); idle();
        h_rd = 1; l_irq_clr = 1; tick(); idle();
        chk({31'h0, l_irq_n}, 32'h0, "R9 event beats clear");
        l_irq_clr = 1; tick(); idle();
        chk({31'h0, l_irq_n}, 32'h1, "R9 clear alone");

        // R6 host drain on down mb3 byte1
        h_irq_cfg = 6'h2D;
        h_wr = 1; h_mb = 3; h_be = 4'b0010; tick(); idle();
        chk({31'h0, h_irq_n}, 32'h1, "R6 no irq before drain");
        l_rd = 1; l_mb = 3; l_be = 4'b0010; tick(); idle();
        chk({31'h0, h_irq_n}, 32'h0, "R6 host drain irq");
        h_irq_clr = 1; tick(); idle();
        chk({31'h0, h_irq_n}, 32'h1, "R9 host clear");
        // R6 host fill on up mb2 byte3
        h_irq_cfg = 6'h3B;
        l_wr = 1; l_mb = 2; l_be = 4'b1000; tick(); idle();
        chk({31'h0, h_irq_n}, 32'h0, "R6 host fill irq");
        h_irq_clr = 1; tick(); idle();

        // R10 / R11 pin path
        h_irq_cfg = 6'h3F; h_mb = 3;
        pin_mode = 0; pin_stb = 1; pin_data = 8'h77; tick(); idle();
        chk({31'h0, up_full[15]}, 32'h0, "R10 pin strobe ignored when off");
        chk({31'h0, h_irq_n}, 32'h1, "R10 no irq when off");
        pin_mode = 1; pin_stb = 1; pin_data = 8'h9C; tick(); idle();
        chk({31'h0, up_full[15]}, 32'h1, "R10 pin write sets flag");
        chk({31'h0, h_irq_n}, 32'h0, "R11 pin write raises host irq");
        l_wr = 1; l_mb = 3; l_be = 4'hF; l_wdata = 32'h12345678; tick(); idle();
        chk(h_rdata, 32'h9C345678, "R10 local write to pin byte ignored");
        chk({28'h0, up_full[15:12]}, 32'hF, "R10 other bytes written");
        tick();

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule